// File: doc/BRIEF.md
# Per-Area Bus Wait-State Generator

This block sets the timing of accesses on an external memory bus whose address space is split into seven areas. A requester offers an access as a valid/ready transaction made of an area number and a burst flag. Once the access is accepted, the block counts out the wait cycles programmed for that area. It then pulses a completion output for each beat. After the final beat it holds the bus idle for the area's programmed gap before it accepts the next access.

Areas 0, 5 and 6 can be set up for burst-ROM operation. On these areas, a flagged access produces 4, 8, 16 or 32 beats. The first beat uses the area's wait count and each later beat uses the area's pitch count. Wait, pitch and idle counts all come from the same non-linear 3-bit code table. Three 32-bit configuration words are loaded through a write port that takes a select code.

Handshake rules: `req_ready` is high only while the block is idle. An access is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the requester must hold `req_valid`, `req_area` and `req_burst` steady. A held request is never lost: it is taken on the first ready cycle.

Top module: `bus_wait_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `busy` is 0 and `beat_done` is 0. All configuration fields reset to code 0, which means no waits, no idle gap and no burst.
- R2: Codes 0..7 map to 0, 1, 2, 3, 6, 9, 12 and 15 cycles. If an access is accepted at edge k and its area's wait count is W, the first `beat_done` pulse is high in the cycle that starts at edge k+W.
- R3: Configuration select 0 writes the wait word. Its wait fields are at bits 5:3 for area 0, 8:6 for area 1, 11:9 for area 2, 15:13 for area 3, 19:17 for area 4, 25:23 for area 5 and 31:29 for area 6. Each area takes only its own field.
- R4: Select 2 writes the burst word. Area 0 uses bits 2:0, area 5 uses bits 5:3 and area 6 uses bits 8:6. With `req_burst` high, codes 1, 2, 3 and 4 give 4, 8, 16 and 32 beats. Codes 0 and 5..7, or `req_burst` low, give a single beat.
- R5: Within a burst, each beat after the first is 1+P cycles after the previous beat. P is the decoded pitch code from the wait word: bits 2:0 for area 0, 22:20 for area 5 and 28:26 for area 6.
- R6: Areas 1 to 4 always perform a single beat, whatever the value of `req_burst`.
- R7: `last_beat` pulses exactly once per access, in the same cycle as the final `beat_done`.
- R8: Select 1 writes the idle word, with area a at bits 4a+2:4a. Bits 30:28 have no effect. If I is the decoded idle count, `req_ready` returns exactly I+1 cycles after the cycle of the final beat.
- R9: `busy` is high from the cycle after acceptance until `req_ready` returns, including the idle gap. It is always the inverse of `req_ready`.
- R10: A request held valid during the idle gap is accepted on the first cycle `req_ready` is high, and it then completes normally.
- R11: A configuration write takes effect for accesses accepted after its edge. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 wait/pitch, 1 idle, 2 burst, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept an access |
| req_area | input | 3 | Area of the access (0..6) |
| req_burst | input | 1 | Ask for a burst where the area allows it |
| beat_done | output | 1 | One-cycle pulse per completed beat |
| last_beat | output | 1 | Marks the final beat of an access |
| busy | output | 1 | Access or idle gap in progress |

## Verification
The assertions assume that a pending request keeps its valid, area and burst inputs steady until it is accepted. They also assume the area number is 0 to 6 and that configuration is written only while the block is idle. The bench raises a request and drops it only after the acceptance edge. It uses areas 0..6 only, and it performs every configuration write between accesses. Under these conditions, the counts that the assertions check on a later cycle cannot change underneath them.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int AREAS  = 7;
  localparam int AREA_W = 3;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;
  localparam int BEAT_W = 6;
  localparam int WORD_W = 32;

  localparam logic [1:0] SEL_WAIT  = 2'd0;
  localparam logic [1:0] SEL_IDLE  = 2'd1;
  localparam logic [1:0] SEL_BURST = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_GAP} seq_st_t;

  // code -> cycles: 0..3 linear, then steps of three up to 15
  function automatic logic [CNT_W-1:0] dec_cycles(input logic [CODE_W-1:0] c);
    int v;
    v = int'(c);
    if (v < 4) return CNT_W'(v);
    return CNT_W'(3 * v - 6);
  endfunction

  function automatic int wait_lsb(input int a);
    case (a)
      0: return 3;
      1: return 6;
      2: return 9;
      3: return 13;
      4: return 17;
      5: return 23;
      default: return 29;
    endcase
  endfunction

  function automatic bit has_burst(input int a);
    return (a == 0) || (a == 5) || (a == 6);
  endfunction

  function automatic int pitch_lsb(input int a);
    case (a)
      5: return 20;
      6: return 26;
      default: return 0;
    endcase
  endfunction

  function automatic int burst_lsb(input int a);
    case (a)
      5: return 3;
      6: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [BEAT_W-1:0] beats_of(input logic [CODE_W-1:0] c);
    case (c)
      3'd1: return BEAT_W'(4);
      3'd2: return BEAT_W'(8);
      3'd3: return BEAT_W'(16);
      3'd4: return BEAT_W'(32);
      default: return BEAT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/bwg_cfg_regs.sv
module bwg_cfg_regs
  import bwg_pkg::*;
#(
  parameter int N_AREA = AREAS,
  parameter int CW     = CODE_W,
  parameter int DW     = WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [N_AREA-1:0][CW-1:0] wait_code,
  output logic [N_AREA-1:0][CW-1:0] pitch_code,
  output logic [N_AREA-1:0][CW-1:0] idle_code,
  output logic [N_AREA-1:0][CW-1:0] burst_code
);
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  for (genvar a = 0; a < N_AREA; a++) begin : g_area
    localparam int WL = wait_lsb(a);
    localparam int IL = 4 * a;
    logic [CW-1:0] wait_q, idle_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wait_q <= '0;
        idle_q <= '0;
      end else if (cfg_we) begin
        if (cfg_sel == SEL_WAIT) wait_q <= cfg_wdata[WL +: CW];
        if (cfg_sel == SEL_IDLE) idle_q <= cfg_wdata[IL +: CW];
      end
    end
    assign wait_code[a] = wait_q;
    assign idle_code[a] = idle_q;

    if (has_burst(a)) begin : g_brst
      localparam int PL = pitch_lsb(a);
      localparam int BL = burst_lsb(a);
      logic [CW-1:0] pitch_q, burst_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pitch_q <= '0;
          burst_q <= '0;
        end else if (cfg_we) begin
          if (cfg_sel == SEL_WAIT)  pitch_q <= cfg_wdata[PL +: CW];
          if (cfg_sel == SEL_BURST) burst_q <= cfg_wdata[BL +: CW];
        end
      end
      assign pitch_code[a] = pitch_q;
      assign burst_code[a] = burst_q;
    end else begin : g_plain
      assign pitch_code[a] = '0;
      assign burst_code[a] = '0;
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(wait_code) && $stable(idle_code) && $stable(burst_code))); // R11
endmodule

// File: rtl/bwg_seq.sv
module bwg_seq
  import bwg_pkg::*;
#(
  parameter int N_AREA = AREAS,
  parameter int AW     = AREA_W,
  parameter int CW     = CODE_W,
  parameter int NW     = CNT_W,
  parameter int BW     = BEAT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [AW-1:0]             req_area,
  input  logic                      req_burst,
  input  logic [N_AREA-1:0][CW-1:0] wait_code,
  input  logic [N_AREA-1:0][CW-1:0] pitch_code,
  input  logic [N_AREA-1:0][CW-1:0] idle_code,
  input  logic [N_AREA-1:0][CW-1:0] burst_code,
  output logic                      req_ready,
  output logic                      beat_done,
  output logic                      last_beat,
  output logic                      busy
);
  localparam logic [AW-1:0] TOP_AREA = AW'(N_AREA - 1);

  seq_st_t        state;
  logic [NW-1:0]  cnt;
  logic [BW-1:0]  beats_left;
  logic [AW-1:0]  cur_area;
  logic           accept;
  logic [CW-1:0]  in_wait, in_burst, cur_pitch, cur_idle;
  logic [NW-1:0]  idle_cyc;

  always_comb begin
    in_wait   = '0;
    in_burst  = '0;
    cur_pitch = '0;
    cur_idle  = '0;
    if (req_area <= TOP_AREA) begin
      in_wait  = wait_code[req_area];
      in_burst = burst_code[req_area];
    end
    if (cur_area <= TOP_AREA) begin
      cur_pitch = pitch_code[cur_area];
      cur_idle  = idle_code[cur_area];
    end
  end

  assign idle_cyc  = dec_cycles(cur_idle);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (state != ST_IDLE);
  assign beat_done = (state == ST_WAIT) && (cnt == '0);
  assign last_beat = beat_done && (beats_left == BW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      beats_left <= '0;
      cur_area   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cnt        <= dec_cycles(in_wait);
            beats_left <= req_burst ? beats_of(in_burst) : BW'(1);
            cur_area   <= req_area;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - NW'(1);
          end else if (beats_left != BW'(1)) begin
            beats_left <= beats_left - BW'(1);
            cnt        <= dec_cycles(cur_pitch);
          end else if (idle_cyc == '0) begin
            state <= ST_IDLE;
          end else begin
            cnt   <= idle_cyc - NW'(1);
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - NW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R9
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_wait == '0) |=> beat_done); // R2
  AST_SINGLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_burst && in_wait == '0) |=> last_beat); // R4
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && cur_idle == '0) |=> req_ready); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_area) && $stable(req_burst))); // R10
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int N_AREA = AREAS,
  parameter int AW     = AREA_W,
  parameter int CW     = CODE_W,
  parameter int DW     = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_area,
  input  logic          req_burst,
  output logic          beat_done,
  output logic          last_beat,
  output logic          busy
);
  logic [N_AREA-1:0][CW-1:0] wait_code, pitch_code, idle_code, burst_code;

  bwg_cfg_regs #(.N_AREA(N_AREA), .CW(CW), .DW(DW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .wait_code  (wait_code),
    .pitch_code (pitch_code),
    .idle_code  (idle_code),
    .burst_code (burst_code)
  );

  bwg_seq #(.N_AREA(N_AREA), .AW(AW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_area   (req_area),
    .req_burst  (req_burst),
    .wait_code  (wait_code),
    .pitch_code (pitch_code),
    .idle_code  (idle_code),
    .burst_code (burst_code),
    .req_ready  (req_ready),
    .beat_done  (beat_done),
    .last_beat  (last_beat),
    .busy       (busy)
  );
endmodule

// File: tb/sim_bus_wait_gen.sv
module sim_bus_wait_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_area = '0;
  logic        req_burst = 1'b0;
  logic        req_ready, beat_done, last_beat, busy;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bus_wait_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_area(req_area), .req_burst(req_burst), .beat_done(beat_done),
    .last_beat(last_beat), .busy(busy)
  );

  function automatic int cyc(input int c);
    case (c)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 6;  5: return 9;  6: return 12; default: return 15;
    endcase
  endfunction

  function automatic int wpos(input int a);
    case (a)
      0: return 3; 1: return 6; 2: return 9; 3: return 13;
      4: return 17; 5: return 23; default: return 29;
    endcase
  endfunction

  function automatic int ppos(input int a);
    return (a == 0) ? 0 : (a == 5) ? 20 : 26;
  endfunction

  function automatic int bpos(input int a);
    return (a == 0) ? 0 : (a == 5) ? 3 : 6;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic run_acc(input int area, input bit brst,
                         output int beats, output int first, output int smin,
                         output int smax, output int lastpos, output int nlast,
                         output int lastc, output int tail, output int berr);
    int n;
    beats = 0; first = 0; smin = 9999; smax = 0; lastpos = 0; nlast = 0;
    lastc = 0; tail = 0; berr = 0; n = 0;
    @(negedge clk);
    req_area = 3'(area); req_burst = brst; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (busy === req_ready) berr++;
      if (beat_done) begin
        beats++;
        if (beats == 1) first = n;
        else begin
          if (n - lastc < smin) smin = n - lastc;
          if (n - lastc > smax) smax = n - lastc;
        end
        lastc = n;
      end
      if (last_beat) begin nlast++; lastpos = n; end
      if (req_ready) begin tail = n - lastc; break; end
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int beats, first, smin, smax, lastpos, nlast, lastc, tail, berr, berr_all;
    logic [31:0] w;
    berr_all = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && busy === 1'b0 && beat_done === 1'b0, "R1",
        {busy, beat_done}, 0);

    // R2 R3 wait decode and field positions
    for (int a = 0; a < 7; a++) begin
      for (int c = 0; c < 8; c++) begin
        w = '0;
        for (int b = 0; b < 7; b++) w[wpos(b) +: 3] = (b == a) ? 3'(c) : 3'(c ^ 5);
        wr(2'd0, w);
        run_acc(a, 1'b0, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
        berr_all += berr;
        chk(first == cyc(c) + 1 && beats == 1, "R2/R3 wait", first, cyc(c) + 1);
      end
    end
    wr(2'd0, 32'h0);

    // R8 idle decode, field positions, bits 30:28 ignored
    for (int a = 0; a < 7; a++) begin
      for (int c = 0; c < 8; c++) begin
        w = 32'h7000_0000;
        for (int b = 0; b < 7; b++) w[4*b +: 3] = (b == a) ? 3'(c) : 3'(7 - c);
        wr(2'd1, w);
        run_acc(a, 1'b0, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
        berr_all += berr;
        chk(tail == cyc(c) + 1, "R8 idle", tail, cyc(c) + 1);
      end
    end
    wr(2'd1, 32'h0);
    // R9 busy is inverse of ready through all accesses so far
    chk(berr_all == 0, "R9 busy", berr_all, 0);

    // R4 R5 R7 burst sweep on areas 0, 5, 6
    for (int k = 0; k < 3; k++) begin
      int a;
      a = (k == 0) ? 0 : (k == 1) ? 5 : 6;
      for (int c = 1; c < 8; c++) begin
        int exp_beats, p;
        p = (c + k) % 8;
        exp_beats = (c <= 4) ? (2 << c) : 1;
        w = '0;
        w[wpos(a) +: 3] = 3'd2;
        w[ppos(a) +: 3] = 3'(p);
        wr(2'd0, w);
        w = '0;
        w[bpos(a) +: 3] = 3'(c);
        wr(2'd2, w);
        run_acc(a, 1'b1, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
        chk(beats == exp_beats && first == 3, "R4 beats", beats, exp_beats);
        if (exp_beats > 1)
          chk(smin == cyc(p) + 1 && smax == cyc(p) + 1, "R5 pitch", smax, cyc(p) + 1);
        chk(nlast == 1 && lastpos == lastc, "R7 last", lastpos, lastc);
      end
    end

    // R4 burst flag low gives one beat
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0000_01DB);
    run_acc(0, 1'b0, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
    chk(beats == 1 && nlast == 1, "R4 flag low", beats, 1);

    // R6 areas 1..4 ignore burst request
    wr(2'd2, 32'hFFFF_FFFF);
    for (int a = 1; a < 5; a++) begin
      run_acc(a, 1'b1, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
      chk(beats == 1 && nlast == 1, "R6 no burst", beats, 1);
    end
    wr(2'd2, 32'h0);

    // R10 held request during idle gap (area 2 idle code 4 -> 6 cycles)
    wr(2'd1, 32'h0000_0400);
    begin
      int n;
      n = 0;
      @(negedge clk);
      req_area = 3'd2; req_burst = 1'b0; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      n = 1;
      while (!req_ready && n < 100) begin @(negedge clk); n++; end
      chk(n == 8, "R10 ready return", n, 8);
      @(negedge clk);
      req_valid = 1'b0;
      chk(beat_done === 1'b1 && busy === 1'b1, "R10 held accepted", beat_done, 1);
      while (!req_ready) @(negedge clk);
    end
    wr(2'd1, 32'h0);

    // R11 select 3 writes nothing
    wr(2'd0, 32'h0000_0018);
    wr(2'd3, 32'h0000_0000);
    run_acc(0, 1'b0, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
    chk(first == 4, "R11 sel3 ignored", first, 4);
    wr(2'd0, 32'h0000_0008);
    run_acc(0, 1'b0, beats, first, smin, smax, lastpos, nlast, lastc, tail, berr);
    chk(first == 2, "R11 new value used", first, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule